// File: doc/BRIEF.md
# Serial Clock Generator with Separate High and Low Phase Counts

This block derives the serial clock (SCK) of a serial flash controller from its source clock. One 32-bit clock register, written through a strobe, holds three 6-bit fields and a source-select bit. The divider and the low count together fix where each SCK period ends. The high count fixes how many source cycles SCK stays high at the start of each period. Because the two phases are set apart, the duty cycle need not be 50% and odd divide ratios work.

The transfer engine raises `xfer_en` while it wants SCK to run. It shifts its next bit out on `shift_stb`, which accompanies each falling SCK edge, and captures input on `sample_stb`, which accompanies each rising edge. SCK rests low while no transfer runs. A period is never cut short: a new configuration, and a stop request, take effect only at a period boundary.

The controller is a three-state machine:
- `SCK_IDLE`: SCK is low and the phase counter is held at zero. It goes to `SCK_HIGH` on `xfer_en` (start).
- `SCK_HIGH`: SCK is high. It goes to `SCK_LOW` when the phase reaches the high count (fall).
- `SCK_LOW`: SCK is low. When the phase reaches the terminal count it goes to `SCK_HIGH` if `xfer_en` is still high (wrap), and otherwise to `SCK_IDLE` (stop).

A snapshot of the decoded register is taken on every entry into `SCK_HIGH`.

Top module: `spi_sck_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `sck`, `shift_stb` and `sample_stb` are 0.
- R2: The clock register fields sit at fixed positions: divider in bits 17:12, high count in bits 11:6, low count in bits 5:0, and source select in bit 31. `src_sel` shows bit 31 of the last write from the cycle after that write.
- R3: With no transfer running, `sck` stays low and neither strobe fires.
- R4: The terminal count T is the smaller of max(divider,1) and max(low count,1). Each SCK period lasts T+1 source cycles.
- R5: SCK is high for H+1 cycles at the start of each period and low for the remaining T−H cycles. H is the high count, clamped to T−1 when it is not below T.
- R6: `sample_stb` is high for exactly the one cycle in which `sck` has just risen. `shift_stb` is high for exactly the one cycle in which `sck` has just fallen. The two strobes are never high together.
- R7: When `xfer_en` is first seen high at a clock edge with the block idle, `sck` and `sample_stb` are high from that edge on.
- R8: A register write made during a period does not change that period. The new values apply from the next period start.
- R9: When `xfer_en` drops, the current period still completes with its full high and low phases. SCK then stays low.
- R10: With the divider and low count both set to n and the high count set to (n+1)/2−1, the period is n+1 cycles for every n from 1 to 63. This gives the fastest rate of source/2 and the slowest of source/64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Clock register write strobe |
| cfg_wdata | input | 32 | Clock register write data |
| xfer_en | input | 1 | Transfer running; keep SCK toggling |
| src_sel | output | 1 | Decoded clock-source select bit |
| sck | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle strobe on each SCK fall |
| sample_stb | output | 1 | One-cycle strobe on each SCK rise |

## Verification
The assertions rely on the clamping in the register decode, so they accept any register value, including zero and out-of-order fields. They do assume that `xfer_en` and the write strobe are synchronous and change only between clock edges. The bench drives every input on the falling clock edge. It sweeps every divider, high and low combination from 0 to 7, including the degenerate ones. It also sweeps the full range of the balanced setting from n=1 to n=63.

// File: rtl/spick_pkg.sv
package spick_pkg;

    typedef enum logic [1:0] {
        SCK_IDLE = 2'd0,
        SCK_HIGH = 2'd1,
        SCK_LOW  = 2'd2
    } sck_state_e;

endpackage

// File: rtl/spick_cfg_decode.sv
module spick_cfg_decode #(
    parameter int REG_W   = 32,
    parameter int FW      = 6,
    parameter int DIV_LSB = 12,
    parameter int HI_LSB  = 6,
    parameter int LO_LSB  = 0,
    parameter int SRC_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic              src_sel,
    output logic [FW-1:0]     term_cnt,
    output logic [FW-1:0]     high_cnt
);

    localparam logic [FW-1:0] ONE = FW'(1);

    logic [FW-1:0] div_q, hi_q, lo_q;
    logic          src_q;
    logic [FW-1:0] div_c, lo_c, term_c;

    // Only the decoded fields are stored; other bits carry no state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= ONE;
            hi_q  <= '0;
            lo_q  <= ONE;
            src_q <= 1'b0;
        end else if (we) begin
            div_q <= wdata[DIV_LSB +: FW];
            hi_q  <= wdata[HI_LSB  +: FW];
            lo_q  <= wdata[LO_LSB  +: FW];
            src_q <= wdata[SRC_BIT];
        end
    end

    // Clamp: the period is at least two cycles and the high phase always
    // leaves at least one low cycle.
    always_comb begin
        div_c    = (div_q == '0) ? ONE : div_q;
        lo_c     = (lo_q  == '0) ? ONE : lo_q;
        term_c   = (lo_c < div_c) ? lo_c : div_c;
        term_cnt = term_c;
        high_cnt = (hi_q >= term_c) ? (term_c - ONE) : hi_q;
    end

    assign src_sel = src_q;

endmodule

// File: rtl/spick_shadow.sv
module spick_shadow #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] term_in,
    input  logic [FW-1:0] high_in,
    output logic [FW-1:0] term_q,
    output logic [FW-1:0] high_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_q <= FW'(1);
            high_q <= '0;
        end else if (load) begin
            term_q <= term_in;
            high_q <= high_in;
        end
    end

endmodule

// File: rtl/spick_phase_ctr.sv
module spick_phase_ctr #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [FW-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase <= '0;
        else if (clr) phase <= '0;
        else if (inc) phase <= phase + FW'(1);
    end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spick_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int FW      = 6,
    parameter int DIV_LSB = 12,
    parameter int HI_LSB  = 6,
    parameter int LO_LSB  = 0,
    parameter int SRC_BIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             xfer_en,
    output logic             src_sel,
    output logic             sck,
    output logic             shift_stb,
    output logic             sample_stb
);

    sck_state_e    state_q, state_d;
    logic [FW-1:0] term_nx, hi_nx;
    logic [FW-1:0] term_s, hi_s;
    logic [FW-1:0] phase;
    logic          period_load, ctr_clr, ctr_inc;
    logic          sck_q, shift_q, sample_q;

    spick_cfg_decode #(
        .REG_W(REG_W), .FW(FW), .DIV_LSB(DIV_LSB),
        .HI_LSB(HI_LSB), .LO_LSB(LO_LSB), .SRC_BIT(SRC_BIT)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .src_sel  (src_sel),
        .term_cnt (term_nx),
        .high_cnt (hi_nx)
    );

    spick_shadow #(.FW(FW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (period_load),
        .term_in (term_nx),
        .high_in (hi_nx),
        .term_q  (term_s),
        .high_q  (hi_s)
    );

    spick_phase_ctr #(.FW(FW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .phase (phase)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCK_IDLE: if (xfer_en)          state_d = SCK_HIGH;
            SCK_HIGH: if (phase == hi_s)    state_d = SCK_LOW;
            SCK_LOW:  if (phase == term_s)  state_d = xfer_en ? SCK_HIGH : SCK_IDLE;
            default:                        state_d = SCK_IDLE;
        endcase
    end

    assign period_load = (state_q != SCK_HIGH) && (state_d == SCK_HIGH);
    assign ctr_clr     = period_load || (state_d == SCK_IDLE);
    assign ctr_inc     = (state_q != SCK_IDLE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCK_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, aligned with the state they describe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
        end else begin
            sck_q    <= (state_d == SCK_HIGH);
            sample_q <= period_load;
            shift_q  <= (state_q == SCK_HIGH) && (state_d == SCK_LOW);
        end
    end

    assign sck        = sck_q;
    assign shift_stb  = shift_q;
    assign sample_stb = sample_q;

endmodule

// File: rtl/spick_chk.sv
module spick_chk #(
    parameter int FW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_en,
    input logic          sck,
    input logic          shift_stb,
    input logic          sample_stb,
    input logic [FW-1:0] hi_s,
    input logic [FW-1:0] term_s
);

    logic [FW:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hcnt <= '0;
        else if (sck) hcnt <= sample_stb ? (FW+1)'(1) : hcnt + (FW+1)'(1);
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && !sck) |=> !sck); // R3
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && sample_stb)); // R6
    AST_SAMPLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sck && !$past(sck))); // R6
    AST_SHIFT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (!sck && $past(sck))); // R6
    AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (hcnt == ((FW+1)'(hi_s) + (FW+1)'(1)))); // R5
    AST_HI_BELOW_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        hi_s < term_s); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> ($stable(hi_s) && $stable(term_s))); // R8

endmodule

bind spi_sck_gen spick_chk #(.FW(FW)) i_spick_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_en    (xfer_en),
    .sck        (sck),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .hi_s       (hi_s),
    .term_s     (term_s)
);

// File: tb/test_spi_sck_gen.sv
module test_spi_sck_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_en = 1'b0;
    logic        src_sel, sck, shift_stb, sample_stb;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk; // 50 MHz

    spi_sck_gen i_spi_sck_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .xfer_en    (xfer_en),
        .src_sel    (src_sel),
        .sck        (sck),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb)
    );

    function automatic logic [31:0] mk(input int src, input int d, input int h, input int l);
        return (32'(src & 1) << 31) | (32'(d & 63) << 12) | (32'(h & 63) << 6) | 32'(l & 63);
    endfunction

    function automatic int exp_term(input int d, input int l);
        int dc, lc;
        dc = (d == 0) ? 1 : d;
        lc = (l == 0) ? 1 : l;
        return (lc < dc) ? lc : dc;
    endfunction

    function automatic int exp_hi(input int h, input int t);
        return (h >= t) ? t - 1 : h;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Called at a negedge where sck has just risen; counts one period.
    task automatic measure(input int hl0, input int cap,
                           output int hl, output int ll, output int ns, output int nf);
        hl = hl0; ll = 0; ns = 0; nf = 0;
        while (sck === 1'b1 && hl < 100) begin
            if (sample_stb) ns++;
            if (shift_stb)  nf++;
            hl++;
            @(negedge clk);
        end
        while (sck === 1'b0 && ll < cap) begin
            if (sample_stb) ns++;
            if (shift_stb)  nf++;
            ll++;
            @(negedge clk);
        end
    endtask

    task automatic run_combo(input int d, input int h, input int l);
        int t, hc, hl, ll, ns, nf;
        t  = exp_term(d, l);
        hc = exp_hi(h, t);
        write_cfg(mk(0, d, h, l));
        xfer_en = 1'b1;
        @(negedge clk);
        check("R7 sck at start", int'(sck), 1);
        check("R7 sample_stb at start", int'(sample_stb), 1);
        measure(0, 100, hl, ll, ns, nf);
        check("R5 high length", hl, hc + 1);
        check("R4 period length", hl + ll, t + 1);
        check("R6 sample strobes per period", ns, 1);
        check("R6 shift strobes per period", nf, 1);
        xfer_en = 1'b0;
        measure(0, t - hc + 3, hl, ll, ns, nf);
        check("R9 last high length", hl, hc + 1);
        check("R9 stays low after stop", ll, t - hc + 3);
        check("R3 no sample strobe when idle", ns, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hl, ll, ns, nf;
        repeat (3) @(negedge clk);
        check("R1 sck in reset", int'(sck), 0);
        check("R1 shift_stb in reset", int'(shift_stb), 0);
        check("R1 sample_stb in reset", int'(sample_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sck after reset", int'(sck), 0);
        check("R1 sample_stb after reset", int'(sample_stb), 0);

        // R2: source select bit
        write_cfg(mk(1, 3, 1, 3));
        check("R2 src_sel set", int'(src_sel), 1);
        write_cfg(mk(0, 3, 1, 3));
        check("R2 src_sel clear", int'(src_sel), 0);

        // R3: idle without transfer
        ns = 0; nf = 0; hl = 0;
        for (int i = 0; i < 20; i++) begin
            if (sck) hl++;
            if (sample_stb) ns++;
            if (shift_stb) nf++;
            @(negedge clk);
        end
        check("R3 sck high cycles while idle", hl, 0);
        check("R3 strobes while idle", ns + nf, 0);

        // R2 R4 R5 R6 R7 R9: sweep small field values
        for (int d = 0; d < 8; d++)
            for (int h = 0; h < 8; h++)
                for (int l = 0; l < 8; l++)
                    run_combo(d, h, l);

        // R2: fields at full-width positions
        run_combo(40, 7, 9);
        run_combo(9, 20, 40);

        // R8: write during a period applies from the next one
        write_cfg(mk(0, 6, 2, 6));
        xfer_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = mk(0, 3, 0, 3);
        @(negedge clk);
        cfg_we = 1'b0;
        measure(1, 100, hl, ll, ns, nf);
        check("R8 old high kept", hl, 3);
        check("R8 old low kept", ll, 4);
        measure(0, 100, hl, ll, ns, nf);
        check("R8 new high applied", hl, 1);
        check("R8 new low applied", ll, 3);
        xfer_en = 1'b0;
        repeat (20) @(negedge clk);

        // R10: balanced setting over the full range
        for (int n = 1; n < 64; n++) begin
            write_cfg(mk(0, n, (n + 1) / 2 - 1, n));
            xfer_en = 1'b1;
            @(negedge clk);
            measure(0, 100, hl, ll, ns, nf);
            check("R10 period", hl + ll, n + 1);
            check("R10 high", hl, (n + 1) / 2);
            xfer_en = 1'b0;
            repeat (70) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule